// File: doc/BRIEF.md
# Dual-Interrupt GPIO Bank With Wakeup

This block is a bank of general-purpose lines with a 32-bit register interface. Each line can be set as an input or an output. Input lines are synchronized and checked for rising edges, falling edges, a high level and a low level. Each check has its own enable bit. A detection sets the line's bit in two separate status registers. Each status register has its own enable register and drives its own interrupt output, so two different consumers can serve the same events with different masks.

Software changes single bits atomically through set and clear alias addresses for the output data, the wakeup enables and both interrupt enables. A wakeup request is produced when an enabled line sees an event while the configuration allows wakeup and selects an idle mode. Byte and halfword writes are lined up to their lane and merged into the full register.

Sources that detect a level stay asserted while the level lasts. Clearing their status bit therefore has no lasting effect until the input changes, the line becomes an output, or the level enable is dropped. Debounce registers are plain storage.

Top module: `gpio_bank`

## Requirements
- R1: After reset the following read as zero: configuration, both status registers, both enables, wakeup enable, all four detect registers, debounce enable, debounce time and output data. The output-enable register reads all ones, which makes every line an input. Control reads 2, the status word at byte 0x14 reads 1, and the identity word at byte 0x00 reads the REVISION parameter.
- R2: Asserting reg_rd returns, one clock later on reg_rdata, the whole word at reg_addr[7:2]. Unmapped addresses read 0. The data-in word at 0x38 returns the synchronized pin levels.
- R3: A rising-edge enable (0x48) or falling-edge enable (0x4C) bit lets a matching transition on an input line (output-enable bit at 0x34 is 1) set that line's bit in status A (0x18) and in status B (0x28) together. A line whose output-enable bit is 0 never sets status.
- R4: An input line whose synchronized level is 1 with its high-level bit (0x44) set, or 0 with its low-level bit (0x40) set, sets its status bits on every cycle. Writing a one to clear it leaves the bit set. Changes to output enable or to the level registers take effect on the following cycle.
- R5: Writing ones to a status register clears those bits in that register only. Zero bits have no effect. A detection in the same cycle wins over the clear.
- R6: irq_a is the OR of (status A AND enable A at 0x1C), and irq_b is the OR of (status B AND enable B at 0x2C). Both are registered and change on the same edge as the registers they depend on.
- R7: The clear/set aliases are: enable A at 0x60/0x64, enable B at 0x70/0x74, wakeup enable at 0x80/0x84, output data at 0x90/0x94. Each one clears or sets only the bits written as one. Each reads back its underlying register.
- R8: The configuration word (0x10) keeps only the bits in 0x1D: bit 0 auto-idle, bit 2 wake enable, bits 4:3 idle mode. Writing bit 1 restores the R1 values for every register except output data, and then stores the written configuration. An idle-mode value of 3 is refused and the field keeps its value from before the write.
- R9: wake_req goes high for the cycle after a detection on a line whose wakeup-enable bit (0x20) is set. It does so only while configuration bit 2 is 1 and the idle-mode field is not 0.
- R10: reg_size selects the access width: 0 is a byte, 1 is a halfword, 2 is a word. The low bits of reg_wdata are shifted to the lane given by reg_addr[1:0]. Ordinary registers merge the shifted lanes into their current contents. Status and alias addresses use the shifted value alone, with zeros elsewhere.
- R11: Writes to the identity word, the status word at 0x14 and data-in are ignored. Control (0x30) keeps 3 bits.
- R12: pin_out is the output data AND NOT output enable. It updates on the same edge as those registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address |
| reg_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| reg_wdata | input | 32 | Write data, right-aligned |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| pin_in | input | LINES | Asynchronous line levels |
| pin_out | output | LINES | Driven levels for output lines |
| irq_a | output | 1 | Interrupt from status A and enable A |
| irq_b | output | 1 | Interrupt from status B and enable B |
| wake_req | output | 1 | Wakeup request |

## Verification
The bench builds the bank with LINES at 32, so line 31 and the upper byte and halfword lanes can be reached by sub-word writes and by the data-in read. SYNC_STAGES is 2, which gives a known latency from a pin change to the status update: the bench samples the one-cycle wakeup pulse with a counter and checks edge events after a fixed wait. REVISION is set to a value other than the default, so the identity read shows that the parameter reaches the register.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned IDX_W  = ADDR_W - 2;

  // access widths on reg_size
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // word indices (byte offset / 4); software decodes these
  localparam logic [IDX_W-1:0] W_IDENT   = 6'h00;
  localparam logic [IDX_W-1:0] W_CFG     = 6'h04;
  localparam logic [IDX_W-1:0] W_DONE    = 6'h05;
  localparam logic [IDX_W-1:0] W_STA     = 6'h06;
  localparam logic [IDX_W-1:0] W_ENA     = 6'h07;
  localparam logic [IDX_W-1:0] W_WKEN    = 6'h08;
  localparam logic [IDX_W-1:0] W_STB     = 6'h0A;
  localparam logic [IDX_W-1:0] W_ENB     = 6'h0B;
  localparam logic [IDX_W-1:0] W_CTRL    = 6'h0C;
  localparam logic [IDX_W-1:0] W_OE      = 6'h0D;
  localparam logic [IDX_W-1:0] W_DIN     = 6'h0E;
  localparam logic [IDX_W-1:0] W_DOUT    = 6'h0F;
  localparam logic [IDX_W-1:0] W_LOW     = 6'h10;
  localparam logic [IDX_W-1:0] W_HIGH    = 6'h11;
  localparam logic [IDX_W-1:0] W_RISE    = 6'h12;
  localparam logic [IDX_W-1:0] W_FALL    = 6'h13;
  localparam logic [IDX_W-1:0] W_DBEN    = 6'h14;
  localparam logic [IDX_W-1:0] W_DBTIME  = 6'h15;
  localparam logic [IDX_W-1:0] W_ENA_CLR = 6'h18;
  localparam logic [IDX_W-1:0] W_ENA_SET = 6'h19;
  localparam logic [IDX_W-1:0] W_ENB_CLR = 6'h1C;
  localparam logic [IDX_W-1:0] W_ENB_SET = 6'h1D;
  localparam logic [IDX_W-1:0] W_WK_CLR  = 6'h20;
  localparam logic [IDX_W-1:0] W_WK_SET  = 6'h21;
  localparam logic [IDX_W-1:0] W_DO_CLR  = 6'h24;
  localparam logic [IDX_W-1:0] W_DO_SET  = 6'h25;

  localparam logic [2:0] CTRL_RST   = 3'd2;
  localparam int unsigned SRST_BIT  = 1;

  // configuration word, laid out as its bit positions 4..0
  typedef struct packed {
    logic [1:0] idle;
    logic       wake_en;
    logic       srst;
    logic       autoidle;
  } cfg_t;

  function automatic cfg_t cfg_pack(input logic [BUS_W-1:0] v, input cfg_t old);
    cfg_t c;
    c.idle     = (v[4:3] == 2'b11) ? old.idle : v[4:3];
    c.wake_en  = v[2];
    c.srst     = 1'b0;
    c.autoidle = v[0];
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_prev
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_prev <= '0;
    else     q_prev <= chain[STAGES-1];
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect #(
  parameter int LINES = 32
) (
  input  logic [LINES-1:0] cur,
  input  logic [LINES-1:0] prev,
  input  logic [LINES-1:0] is_input,
  input  logic [LINES-1:0] rise_en,
  input  logic [LINES-1:0] fall_en,
  input  logic [LINES-1:0] low_en,
  input  logic [LINES-1:0] high_en,
  output logic [LINES-1:0] evt
);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic up, down, lvl;
    assign up   = cur[i] & ~prev[i] & rise_en[i];
    assign down = ~cur[i] & prev[i] & fall_en[i];
    assign lvl  = (cur[i] & high_en[i]) | (~cur[i] & low_en[i]);
    assign evt[i] = is_input[i] & (up | down | lvl);
  end

endmodule

// File: rtl/gpio_wr_merge.sv
`timescale 1ns/1ps
module gpio_wr_merge
  import gpio_bank_pkg::*;
#(
  parameter int W = BUS_W
) (
  input  logic [1:0]   lane,
  input  logic [1:0]   size,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cur,
  output logic [W-1:0] merged,
  output logic [W-1:0] lone
);

  localparam int SH_W = $clog2(W);

  logic [W-1:0]    base_mask;
  logic [W-1:0]    lane_mask;
  logic [SH_W-1:0] sh;

  always_comb begin
    sh = SH_W'({lane, 3'b000});
    case (size)
      SZ_BYTE: base_mask = W'(8'hFF);
      SZ_HALF: base_mask = W'(16'hFFFF);
      default: begin
        base_mask = '1;
        sh        = '0;
      end
    endcase
    lone      = (wdata & base_mask) << sh;
    lane_mask = base_mask << sh;
    merged    = (cur & ~lane_mask) | lone;
  end

endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int         LINES       = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] REVISION    = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_size,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic              irq_a,
  output logic              irq_b,
  output logic              wake_req
);

  localparam logic [LINES-1:0] ALL_IN = '1;

  logic [IDX_W-1:0] widx;
  logic [1:0]       lane;
  assign widx = reg_addr[ADDR_W-1:2];
  assign lane = reg_addr[1:0];

  // register state
  logic [LINES-1:0] st_a_q, st_b_q, en_a_q, en_b_q, wk_q, oe_q, dout_q;
  logic [LINES-1:0] lo_q, hi_q, rise_q, fall_q, dben_q;
  cfg_t             cfg_q;
  logic [2:0]       ctrl_q;
  logic [7:0]       dbt_q;

  logic [LINES-1:0] st_a_d, st_b_d, en_a_d, en_b_d, wk_d, oe_d, dout_d;
  logic [LINES-1:0] lo_d, hi_d, rise_d, fall_d, dben_d;
  cfg_t             cfg_d;
  logic [2:0]       ctrl_d;
  logic [7:0]       dbt_d;
  logic             irq_a_d, irq_b_d, wake_d;
  logic [LINES-1:0] pin_d;

  // input path
  logic [LINES-1:0] din_cur, din_prev, evt;

  gpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d      (pin_in),
    .q      (din_cur),
    .q_prev (din_prev)
  );

  gpio_detect #(.LINES(LINES)) detect_i (
    .cur      (din_cur),
    .prev     (din_prev),
    .is_input (oe_q),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .low_en   (lo_q),
    .high_en  (hi_q),
    .evt      (evt)
  );

  // read mux, shared by the read port and the sub-word write merge
  logic [BUS_W-1:0] word_at;

  always_comb begin
    case (widx)
      W_IDENT:                       word_at = BUS_W'(REVISION);
      W_CFG:                         word_at = BUS_W'(cfg_q);
      W_DONE:                        word_at = BUS_W'(1);
      W_STA:                         word_at = BUS_W'(st_a_q);
      W_ENA, W_ENA_CLR, W_ENA_SET:   word_at = BUS_W'(en_a_q);
      W_WKEN, W_WK_CLR, W_WK_SET:    word_at = BUS_W'(wk_q);
      W_STB:                         word_at = BUS_W'(st_b_q);
      W_ENB, W_ENB_CLR, W_ENB_SET:   word_at = BUS_W'(en_b_q);
      W_CTRL:                        word_at = BUS_W'(ctrl_q);
      W_OE:                          word_at = BUS_W'(oe_q);
      W_DIN:                         word_at = BUS_W'(din_cur);
      W_DOUT, W_DO_CLR, W_DO_SET:    word_at = BUS_W'(dout_q);
      W_LOW:                         word_at = BUS_W'(lo_q);
      W_HIGH:                        word_at = BUS_W'(hi_q);
      W_RISE:                        word_at = BUS_W'(rise_q);
      W_FALL:                        word_at = BUS_W'(fall_q);
      W_DBEN:                        word_at = BUS_W'(dben_q);
      W_DBTIME:                      word_at = BUS_W'(dbt_q);
      default:                       word_at = '0;
    endcase
  end

  logic [BUS_W-1:0] wr_merged, wr_lone;

  gpio_wr_merge #(.W(BUS_W)) merge_i (
    .lane   (lane),
    .size   (reg_size),
    .wdata  (reg_wdata),
    .cur    (word_at),
    .merged (wr_merged),
    .lone   (wr_lone)
  );

  logic [LINES-1:0] m_line, l_line, clr_a, clr_b;
  logic             soft_rst;
  assign m_line = LINES'(wr_merged);
  assign l_line = LINES'(wr_lone);

  // next-state
  always_comb begin
    en_a_d = en_a_q;  en_b_d = en_b_q;  wk_d   = wk_q;
    oe_d   = oe_q;    dout_d = dout_q;  lo_d   = lo_q;
    hi_d   = hi_q;    rise_d = rise_q;  fall_d = fall_q;
    dben_d = dben_q;  ctrl_d = ctrl_q;  dbt_d  = dbt_q;
    cfg_d  = cfg_q;
    clr_a  = '0;
    clr_b  = '0;
    soft_rst = 1'b0;

    if (reg_wr) begin
      case (widx)
        W_CFG: begin
          soft_rst = wr_merged[SRST_BIT];
          cfg_d    = cfg_pack(wr_merged, cfg_q);
        end
        W_STA:     clr_a  = l_line;
        W_STB:     clr_b  = l_line;
        W_ENA:     en_a_d = m_line;
        W_ENA_CLR: en_a_d = en_a_q & ~l_line;
        W_ENA_SET: en_a_d = en_a_q | l_line;
        W_ENB:     en_b_d = m_line;
        W_ENB_CLR: en_b_d = en_b_q & ~l_line;
        W_ENB_SET: en_b_d = en_b_q | l_line;
        W_WKEN:    wk_d   = m_line;
        W_WK_CLR:  wk_d   = wk_q & ~l_line;
        W_WK_SET:  wk_d   = wk_q | l_line;
        W_DOUT:    dout_d = m_line;
        W_DO_CLR:  dout_d = dout_q & ~l_line;
        W_DO_SET:  dout_d = dout_q | l_line;
        W_CTRL:    ctrl_d = wr_merged[2:0];
        W_OE:      oe_d   = m_line;
        W_LOW:     lo_d   = m_line;
        W_HIGH:    hi_d   = m_line;
        W_RISE:    rise_d = m_line;
        W_FALL:    fall_d = m_line;
        W_DBEN:    dben_d = m_line;
        W_DBTIME:  dbt_d  = wr_merged[7:0];
        default: ;
      endcase
    end

    // a detection in the same cycle wins over a clear
    st_a_d = (st_a_q & ~clr_a) | evt;
    st_b_d = (st_b_q & ~clr_b) | evt;
    wake_d = cfg_q.wake_en && (cfg_q.idle != 2'b00) && |(evt & wk_q);

    if (soft_rst) begin
      st_a_d = '0;  st_b_d = '0;  en_a_d = '0;  en_b_d = '0;
      wk_d   = '0;  lo_d   = '0;  hi_d   = '0;  rise_d = '0;
      fall_d = '0;  dben_d = '0;  dbt_d  = '0;
      oe_d   = ALL_IN;
      ctrl_d = CTRL_RST;
      wake_d = 1'b0;
    end

    irq_a_d = |(st_a_d & en_a_d);
    irq_b_d = |(st_b_d & en_b_d);
    pin_d   = dout_d & ~oe_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_a_q <= '0;  st_b_q <= '0;  en_a_q <= '0;  en_b_q <= '0;
      wk_q   <= '0;  oe_q   <= ALL_IN;  dout_q <= '0;
      lo_q   <= '0;  hi_q   <= '0;  rise_q <= '0;  fall_q <= '0;
      dben_q <= '0;  dbt_q  <= '0;  ctrl_q <= CTRL_RST;
      cfg_q  <= '0;
      irq_a  <= 1'b0;  irq_b <= 1'b0;  wake_req <= 1'b0;
      pin_out <= '0;
    end else begin
      st_a_q <= st_a_d;  st_b_q <= st_b_d;  en_a_q <= en_a_d;  en_b_q <= en_b_d;
      wk_q   <= wk_d;    oe_q   <= oe_d;    dout_q <= dout_d;
      lo_q   <= lo_d;    hi_q   <= hi_d;    rise_q <= rise_d;  fall_q <= fall_d;
      dben_q <= dben_d;  dbt_q  <= dbt_d;   ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      irq_a  <= irq_a_d;  irq_b <= irq_b_d;  wake_req <= wake_d;
      pin_out <= pin_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= word_at;
  end

  // R3: an event lands in both status sets on the next edge
  a_r3_event_both_sets: assert property (@(posedge clk) disable iff (rst)
    ((|evt) && !soft_rst) |=>
      (((st_a_q & $past(evt)) == $past(evt)) && ((st_b_q & $past(evt)) == $past(evt))));

  // R6: each interrupt output tracks its own masked status
  a_r6_irq_a_track: assert property (@(posedge clk) disable iff (rst)
    irq_a == (|(st_a_q & en_a_q)));
  a_r6_irq_b_track: assert property (@(posedge clk) disable iff (rst)
    irq_b == (|(st_b_q & en_b_q)));

  // R8: the refused idle-mode value is never stored
  a_r8_idle_legal: assert property (@(posedge clk) disable iff (rst)
    cfg_q.idle != 2'b11);

  // R9: a wakeup request needs the wake bit and a nonzero idle mode
  a_r9_wake_gate: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> ($past(cfg_q.wake_en) && ($past(cfg_q.idle) != 2'b00)));

endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;

  localparam int         LINES = 32;
  localparam logic [7:0] REV   = 8'h5C;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr;
  logic [1:0]  reg_size;
  logic [31:0] reg_wdata, reg_rdata;
  logic [LINES-1:0] pin_in, pin_out;
  logic        irq_a, irq_b, wake_req;

  always #2.5 clk = ~clk;

  gpio_bank #(.LINES(LINES), .SYNC_STAGES(2), .REVISION(REV)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wake_cnt = 0;
  bit done = 1'b0;

  always @(negedge clk) if (wake_req) wake_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_size = sz; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic settle(input int n = 4);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean();
    wr(8'h48, 0); wr(8'h4C, 0); wr(8'h40, 0); wr(8'h44, 0);
    wr(8'h34, 32'hFFFF_FFFF);
    pin_in = '0;
    settle();
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h1C, 0); wr(8'h2C, 0); wr(8'h20, 0); wr(8'h3C, 0);
  endtask

  task automatic t_reset();
    rdchk(8'h10, 32'h0, "R1 cfg reset");
    rdchk(8'h34, 32'hFFFF_FFFF, "R1 oe reset");
    rdchk(8'h30, 32'h2, "R1 ctrl reset");
    rdchk(8'h14, 32'h1, "R1 done word");
    rdchk(8'h00, {24'h0, REV}, "R1 identity");
    rdchk(8'h18, 32'h0, "R1 status A reset");
    rdchk(8'h54, 32'h0, "R1 debounce time reset");
    rdchk(8'h58, 32'h0, "R2 unmapped read");
    chk("R1 pin_out reset", pin_out, 32'h0);
    chk("R1 irq reset", {30'h0, irq_a, irq_b}, 32'h0);
  endtask

  task automatic t_edges();
    wr(8'h48, 32'h1); wr(8'h4C, 32'h2);
    pin_in = 32'h1; settle();
    rdchk(8'h18, 32'h1, "R3 rise sets status A");
    rdchk(8'h28, 32'h1, "R3 rise sets status B");
    wr(8'h18, 32'h1);
    rdchk(8'h18, 32'h0, "R5 clear status A");
    rdchk(8'h28, 32'h1, "R5 status B untouched");
    wr(8'h28, 32'h1);
    pin_in = 32'h3; settle();
    rdchk(8'h18, 32'h0, "R3 rise on fall-only line");
    pin_in = 32'h1; settle();
    rdchk(8'h18, 32'h2, "R3 falling edge");
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFB); wr(8'h48, 32'h4);
    pin_in = 32'h5; settle();
    rdchk(8'h18, 32'h0, "R3 output line no event");
    clean();
  endtask

  task automatic t_level();
    pin_in = 32'h10; settle();
    wr(8'h44, 32'h10); settle(2);
    rdchk(8'h18, 32'h10, "R4 high level sets");
    wr(8'h18, 32'h10);
    rdchk(8'h18, 32'h10, "R4 level reasserts after clear");
    wr(8'h34, 32'hFFFF_FFEF);
    wr(8'h18, 32'h10);
    rdchk(8'h18, 32'h0, "R4 output line clears");
    wr(8'h34, 32'hFFFF_FFFF); settle(2);
    rdchk(8'h18, 32'h10, "R4 re-eval after oe write");
    wr(8'h44, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    rdchk(8'h18, 32'h0, "R4 cleared after level off");
    wr(8'h40, 32'h20); settle(2);
    rdchk(8'h28, 32'h30, "R4 low level into status B");
    clean();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(8'h48, 32'h1);
    pin_in = 32'h1; settle();
    chk("R6 no enable no irq", {30'h0, irq_a, irq_b}, 32'h0);
    wr(8'h64, 32'h1);
    chk("R6 irq_a on enable", {30'h0, irq_a, irq_b}, 32'h2);
    rdchk(8'h64, 32'h1, "R7 set alias reads enable A");
    wr(8'h74, 32'h1);
    chk("R6 irq_b on enable", {31'h0, irq_b}, 32'h1);
    wr(8'h60, 32'h1);
    chk("R7 clear alias drops irq_a", {31'h0, irq_a}, 32'h0);
    rdchk(8'h60, 32'h0, "R7 clear alias readback");
    wr(8'h28, 32'h1);
    chk("R6 irq_b after status clear", {31'h0, irq_b}, 32'h0);
    wr(8'h84, 32'hF0); wr(8'h80, 32'h30);
    rdchk(8'h20, 32'hC0, "R7 wake enable aliases");
    rdchk(8'h84, 32'hC0, "R7 wake set alias readback");
    wr(8'h64, 32'h6); wr(8'h64, 32'h8);
    rd(8'h1C, v);
    chk("R7 set alias keeps others", v, 32'hE);
    clean();
  endtask

  task automatic t_dout();
    wr(8'h34, 32'hFFFF_FF00);
    wr(8'h94, 32'h10F);
    chk("R12 pin_out low byte", pin_out, 32'h0F);
    wr(8'h90, 32'h3);
    chk("R7 clear data bits", pin_out, 32'h0C);
    rdchk(8'h90, 32'h10C, "R7 data clear alias readback");
    rdchk(8'h3C, 32'h10C, "R7 data out register");
    wr(8'h34, 32'hFFFF_FE00);
    chk("R12 line 8 becomes output", pin_out, 32'h10C);
    clean();
  endtask

  task automatic t_cfg();
    wr(8'h10, 32'h0C);
    rdchk(8'h10, 32'h0C, "R8 cfg store");
    wr(8'h10, 32'h19);
    rdchk(8'h10, 32'h09, "R8 idle 3 refused");
    wr(8'h10, 32'hFFFF_FFE0);
    rdchk(8'h10, 32'h00, "R8 cfg mask");
    wr(8'h3C, 32'hA5); wr(8'h1C, 32'h3); wr(8'h34, 32'h0);
    wr(8'h30, 32'h5); wr(8'h54, 32'h77);
    chk("R12 all outputs", pin_out, 32'hA5);
    wr(8'h10, 32'h06);
    rdchk(8'h10, 32'h04, "R8 cfg after soft reset");
    rdchk(8'h1C, 32'h0, "R8 soft reset enable A");
    rdchk(8'h34, 32'hFFFF_FFFF, "R8 soft reset oe");
    rdchk(8'h30, 32'h2, "R8 soft reset ctrl");
    rdchk(8'h54, 32'h0, "R8 soft reset debounce time");
    rdchk(8'h3C, 32'hA5, "R8 data out kept");
    chk("R8 pins off after soft reset", pin_out, 32'h0);
    wr(8'h10, 32'h0);
    clean();
  endtask

  task automatic t_wake();
    wr(8'h10, 32'h0C); wr(8'h84, 32'h40); wr(8'h48, 32'h40);
    wake_cnt = 0;
    pin_in = 32'h40; settle(6);
    chk("R9 wake pulse", wake_cnt, 32'd1);
    wr(8'h10, 32'h04);
    pin_in = 32'h0; settle();
    wake_cnt = 0;
    pin_in = 32'h40; settle(6);
    chk("R9 no wake with idle 0", wake_cnt, 32'd0);
    wr(8'h10, 32'h0C); wr(8'h80, 32'h40);
    pin_in = 32'h0; settle();
    wake_cnt = 0;
    pin_in = 32'h40; settle(6);
    chk("R9 no wake without line enable", wake_cnt, 32'd0);
    wr(8'h10, 32'h0);
    clean();
  endtask

  task automatic t_subword();
    wr(8'h48, 32'h1122_3344);
    wr(8'h49, 32'hAB, 2'd0);
    rdchk(8'h48, 32'h1122_AB44, "R10 byte merge");
    wr(8'h4A, 32'h5566, 2'd1);
    rdchk(8'h48, 32'h5566_AB44, "R10 halfword merge");
    wr(8'h48, 32'h101);
    pin_in = 32'h101; settle();
    pin_in = 32'h0; settle();
    rdchk(8'h18, 32'h101, "R10 status before byte clear");
    wr(8'h19, 32'hFF, 2'd0);
    rdchk(8'h18, 32'h001, "R10 byte status clear lone");
    wr(8'h64, 32'h101);
    wr(8'h61, 32'h01, 2'd0);
    rdchk(8'h1C, 32'h001, "R10 byte clear alias lone");
    wr(8'h36, 32'h0, 2'd1);
    rdchk(8'h34, 32'h0000_FFFF, "R10 upper halfword lane");
    clean();
  endtask

  task automatic t_readonly();
    pin_in = 32'h8000_0001; settle();
    rdchk(8'h38, 32'h8000_0001, "R2 data in");
    wr(8'h38, 32'h0);
    rdchk(8'h38, 32'h8000_0001, "R11 data in read-only");
    wr(8'h14, 32'h0);
    rdchk(8'h14, 32'h1, "R11 done word read-only");
    wr(8'h00, 32'h0);
    rdchk(8'h00, {24'h0, REV}, "R11 identity read-only");
    wr(8'h30, 32'hFF);
    rdchk(8'h30, 32'h7, "R11 ctrl width");
    pin_in = '0;
    clean();
  endtask

  initial begin
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0;
    reg_size = 2'd2; reg_wdata = '0; pin_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_edges();
    t_level();
    t_irq();
    t_dout();
    t_cfg();
    t_wake();
    t_subword();
    t_readonly();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule